// File: doc/BRIEF.md
# Ethernet Wake-Up Frame Detector

This block watches the byte-wide receive stream of an Ethernet MAC while the system sleeps. Once power-down is requested, every frame is held back from the application and each frame is instead inspected for a reason to wake up. Two kinds of frame can wake the system. The first is a magic packet addressed to this station. The second is a frame that matches one of four programmable pattern filters. Each filter picks frame bytes with a 32-bit mask placed at an 8-bit start offset, runs a CRC-16 over only those bytes, and compares the result with a stored value.

A qualifying frame ends power-down and emits a one-cycle wake pulse. A sticky cause register records which detector fired until it is read. Configuration (filter fields, station address, detector enables) is driven as static inputs by the surrounding MAC control logic.

Top module: `wake_frame_detector`

## Requirements
- R1: After reset `pd_active_o`=0, `fwd_en_o`=1, `wake_o`=0 and `cause_o`=0. At all times `fwd_en_o` is low exactly while power-down is active, so no frame is passed on during power-down.
- R2: A one-cycle `pd_set_i` pulse makes `pd_active_o` high from the next cycle. It stays high until a wake event occurs.
- R3: A wake is decided only on the byte flagged `rx_eof_i`, only when `rx_good_i` is high with it, and only while power-down is active. Frames received outside power-down, and bad frames, never wake.
- R4: Byte index 0 is the byte flagged `rx_sof_i` (first destination-address byte). For filter f, bit j of its mask selects byte `offset+j` into its CRC. Bytes below the offset and bytes whose mask bit is clear have no effect. The CRC is CRC-16 with polynomial 0x8005 and initial value 0xFFFF. Each byte is fed LSB first: feedback = crc[15] xor data bit, shift left, then xor 0x8005 when feedback is 1. A filter hits when the final CRC equals its stored value.
- R5: A filter whose `flt_en_i` bit is 0 never hits.
- R6: A filter whose `flt_ucast_i` bit is 1 rejects any frame with bit 0 of byte 0 set (multicast destination).
- R7: A magic packet is six 0xFF bytes followed immediately by sixteen back-to-back copies of `station_mac_i`, sent most significant byte first (bits 47:40 first). It may start anywhere in the frame. Extra 0xFF bytes before the first copy are allowed. Any other byte inside the copies breaks the match.
- R8: A magic packet wakes only when `magic_en_i`=1, and a filter hit wakes only when `wkfrm_en_i`=1.
- R9: A wake drives `wake_o` high for exactly the one cycle after the end-of-frame byte. `pd_active_o` drops in that same cycle.
- R10: `cause_o[0]` (magic packet) and `cause_o[1]` (filter hit) are set by the wake that caused them and stay set until `stat_rd_i` is high for a cycle. If a new cause arrives in the same cycle as a read, the old bits are cleared and the new bit is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_sof_i | input | 1 | First byte of frame |
| rx_eof_i | input | 1 | Last byte of frame |
| rx_good_i | input | 1 | Frame is error-free, qualified with `rx_eof_i` |
| rx_data_i | input | 8 | Receive byte |
| pd_set_i | input | 1 | Request to enter power-down |
| magic_en_i | input | 1 | Magic-packet detection enable |
| wkfrm_en_i | input | 1 | Filter-based wake enable |
| station_mac_i | input | 48 | Station address, bits 47:40 sent first |
| flt_en_i | input | 4 | Per-filter enable |
| flt_ucast_i | input | 4 | Per-filter unicast-only select |
| flt_offset_i | input | 32 | Per-filter start offset, 8 bits each, filter 0 in bits 7:0 |
| flt_mask_i | input | 128 | Per-filter byte mask, 32 bits each, filter 0 lowest |
| flt_crc_i | input | 64 | Per-filter stored CRC-16, filter 0 lowest |
| stat_rd_i | input | 1 | Status read strobe, clears `cause_o` |
| wake_o | output | 1 | One-cycle wake event |
| pd_active_o | output | 1 | Power-down mode active |
| fwd_en_o | output | 1 | Frames may be forwarded to the application |
| cause_o | output | 2 | Wake cause: bit 0 magic packet, bit 1 filter |

## Verification
The filter path is driven with one base frame and several one-byte edits of it. An edit to a masked-in byte must block the wake. Edits to a masked-out byte, or to a byte below the offset, must not. This separates a correct mask and offset window from one that is shifted or ignored. A multicast copy of the same frame separates the unicast-only check from the CRC check. The magic path is tried with an exact packet, with a packet that has extra leading 0xFF bytes, and with a packet broken in one copy; this tells a correct sequence tracker from one that restarts wrongly or accepts too early. Bad frames, frames outside power-down and disabled detectors show that each gate works on its own. A status read on the same cycle as a new wake shows the set-over-clear order.

// File: rtl/wfd_pkg.sv
package wfd_pkg;
  localparam logic [15:0] CRC_POLY = 16'h8005;
  localparam logic [15:0] CRC_INIT = 16'hFFFF;

  // byte fed LSB first into a left-shifting register
  function automatic logic [15:0] crc16_byte(input logic [15:0] crc_in, input logic [7:0] b);
    logic [15:0] c;
    logic        fb;
    c = crc_in;
    for (int i = 0; i < 8; i++) begin
      fb = c[15] ^ b[i];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction
endpackage

// File: rtl/wfd_frame_tracker.sv
module wfd_frame_tracker #(
  parameter int IDX_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sof_i,
  input  logic [7:0]       data_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             mcast_o
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic [IDX_W-1:0] idx_q;
  logic             mcast_q;

  assign idx_o   = sof_i ? '0 : idx_q;
  assign mcast_o = sof_i ? data_i[0] : mcast_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      mcast_q <= 1'b0;
    end else if (valid_i) begin
      idx_q   <= (idx_o == IDX_MAX) ? IDX_MAX : idx_o + 1'b1;
      mcast_q <= mcast_o;
    end
  end

  assert_idx_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sof_i) |=> (idx_q == IDX_W'(1)));
endmodule

// File: rtl/wfd_pattern_filter.sv
module wfd_pattern_filter
  import wfd_pkg::*;
#(
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 8,
  parameter int MASK_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              sof_i,
  input  logic              eof_i,
  input  logic              good_i,
  input  logic [7:0]        data_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              mcast_i,
  input  logic              en_i,
  input  logic              ucast_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic [15:0]       crc_ref_i,
  output logic              hit_o
);
  localparam int MB = $clog2(MASK_W);

  logic [IDX_W-1:0] rel;
  logic             in_win, sel;
  logic [15:0]      crc_q, crc_base, crc_d;

  assign rel      = idx_i - IDX_W'(off_i);
  assign in_win   = (idx_i >= IDX_W'(off_i)) && (rel < IDX_W'(MASK_W));
  assign sel      = in_win && mask_i[rel[MB-1:0]];
  assign crc_base = sof_i ? CRC_INIT : crc_q;
  assign crc_d    = sel ? crc16_byte(crc_base, data_i) : crc_base;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= CRC_INIT;
    else if (valid_i) crc_q <= crc_d;
  end

  assign hit_o = valid_i && eof_i && good_i && en_i && !(ucast_i && mcast_i)
                 && (crc_d == crc_ref_i);

  // unselected first byte leaves the seed untouched
  assert_crc_seed_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sof_i && !sel) |=> (crc_q == CRC_INIT));
endmodule

// File: rtl/wfd_magic_detect.sv
module wfd_magic_detect #(
  parameter int SYNC_LEN = 6,
  parameter int COPIES   = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic        sof_i,
  input  logic [7:0]  data_i,
  input  logic [47:0] mac_i,
  output logic        found_o
);
  localparam int SW = $clog2(SYNC_LEN + 1);
  localparam int CW = (COPIES > 1) ? $clog2(COPIES) : 1;
  localparam logic [SW-1:0] SYNC_FULL = SW'(SYNC_LEN);
  localparam logic [CW-1:0] LAST_COPY = CW'(COPIES - 1);

  logic [SW-1:0] sync_q, sync_d;
  logic [2:0]    k_q, k_d;
  logic [CW-1:0] copy_q, copy_d;
  logic          found_q, found_d;
  logic [7:0]    exp_b;
  logic          is_ff;

  assign is_ff = (data_i == 8'hFF);

  always_comb begin
    sync_d  = sof_i ? '0 : sync_q;
    k_d     = sof_i ? '0 : k_q;
    copy_d  = sof_i ? '0 : copy_q;
    found_d = sof_i ? 1'b0 : found_q;
    exp_b   = mac_i[47 - 8*k_d -: 8];
    if (valid_i && !found_d) begin
      if (sync_d != SYNC_FULL) begin
        sync_d = is_ff ? sync_d + SW'(1) : '0;
      end else if (data_i == exp_b) begin
        if (k_d == 3'd5) begin
          k_d = '0;
          if (copy_d == LAST_COPY) found_d = 1'b1;
          else                     copy_d  = copy_d + CW'(1);
        end else begin
          k_d = k_d + 3'd1;
        end
      end else if (!(is_ff && k_d == '0 && copy_d == '0)) begin
        // broken sequence: a 0xFF may begin a new sync run
        sync_d = is_ff ? SW'(1) : '0;
        k_d    = '0;
        copy_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      k_q     <= '0;
      copy_q  <= '0;
      found_q <= 1'b0;
    end else if (valid_i) begin
      sync_q  <= sync_d;
      k_q     <= k_d;
      copy_q  <= copy_d;
      found_q <= found_d;
    end
  end

  assign found_o = found_d;

  assert_found_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (found_q && !(valid_i && sof_i)) |=> found_q);
  assert_k_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    k_q <= 3'd5);
endmodule

// File: rtl/wake_frame_detector.sv
module wake_frame_detector #(
  parameter int NUM_FLT  = 4,
  parameter int OFF_W    = 8,
  parameter int MASK_W   = 32,
  parameter int SYNC_LEN = 6,
  parameter int COPIES   = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      rx_valid_i,
  input  logic                      rx_sof_i,
  input  logic                      rx_eof_i,
  input  logic                      rx_good_i,
  input  logic [7:0]                rx_data_i,
  input  logic                      pd_set_i,
  input  logic                      magic_en_i,
  input  logic                      wkfrm_en_i,
  input  logic [47:0]               station_mac_i,
  input  logic [NUM_FLT-1:0]        flt_en_i,
  input  logic [NUM_FLT-1:0]        flt_ucast_i,
  input  logic [NUM_FLT*OFF_W-1:0]  flt_offset_i,
  input  logic [NUM_FLT*MASK_W-1:0] flt_mask_i,
  input  logic [NUM_FLT*16-1:0]     flt_crc_i,
  input  logic                      stat_rd_i,
  output logic                      wake_o,
  output logic                      pd_active_o,
  output logic                      fwd_en_o,
  output logic [1:0]                cause_o
);
  localparam int IDX_W = $clog2((2**OFF_W) + MASK_W);

  logic [IDX_W-1:0]   idx;
  logic               mcast;
  logic [NUM_FLT-1:0] flt_hit;
  logic               magic_found;
  logic               frame_end, hit_magic, hit_frame, wake_d;
  logic               pd_q, wake_q;
  logic [1:0]         cause_q;

  wfd_frame_tracker #(.IDX_W(IDX_W)) u_track (
    .clk_i, .rst_ni, .valid_i(rx_valid_i), .sof_i(rx_sof_i), .data_i(rx_data_i),
    .idx_o(idx), .mcast_o(mcast)
  );

  for (genvar f = 0; f < NUM_FLT; f++) begin : g_flt
    wfd_pattern_filter #(.IDX_W(IDX_W), .OFF_W(OFF_W), .MASK_W(MASK_W)) u_flt (
      .clk_i, .rst_ni,
      .valid_i(rx_valid_i), .sof_i(rx_sof_i), .eof_i(rx_eof_i), .good_i(rx_good_i),
      .data_i(rx_data_i), .idx_i(idx), .mcast_i(mcast),
      .en_i(flt_en_i[f]), .ucast_i(flt_ucast_i[f]),
      .off_i(flt_offset_i[f*OFF_W +: OFF_W]),
      .mask_i(flt_mask_i[f*MASK_W +: MASK_W]),
      .crc_ref_i(flt_crc_i[f*16 +: 16]),
      .hit_o(flt_hit[f])
    );
  end

  wfd_magic_detect #(.SYNC_LEN(SYNC_LEN), .COPIES(COPIES)) u_magic (
    .clk_i, .rst_ni, .valid_i(rx_valid_i), .sof_i(rx_sof_i), .data_i(rx_data_i),
    .mac_i(station_mac_i), .found_o(magic_found)
  );

  assign frame_end = rx_valid_i && rx_eof_i && rx_good_i && pd_q;
  assign hit_magic = frame_end && magic_en_i && magic_found;
  assign hit_frame = pd_q && wkfrm_en_i && (|flt_hit);
  assign wake_d    = hit_magic || hit_frame;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd_q    <= 1'b0;
      wake_q  <= 1'b0;
      cause_q <= '0;
    end else begin
      wake_q <= wake_d;
      if (wake_d)        pd_q <= 1'b0;
      else if (pd_set_i) pd_q <= 1'b1;
      // set wins over read-clear
      cause_q <= (stat_rd_i ? 2'b00 : cause_q) | {hit_frame, hit_magic};
    end
  end

  assign wake_o      = wake_q;
  assign pd_active_o = pd_q;
  assign fwd_en_o    = !pd_q;
  assign cause_o     = cause_q;

  assert_wake_needs_pd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(pd_active_o));
  assert_wake_ends_pd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> !pd_active_o);
  assert_wake_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);
  assert_wake_has_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (cause_o != 2'b00));
  assert_pd_enter_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_set_i && !rx_valid_i) |=> pd_active_o);
endmodule

// File: tb/wake_frame_detector_test.sv
`timescale 1ns/1ps
module wake_frame_detector_test;
  typedef logic [7:0] bq_t[$];

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_good = 0;
  logic [7:0]   rx_data = 0;
  logic         pd_set = 0, magic_en = 0, wkfrm_en = 1, stat_rd = 0;
  logic [47:0]  mac = 48'h02_11_22_33_44_55;
  logic [3:0]   f_en = 0, f_uc = 0;
  logic [7:0]   f_off [4];
  logic [31:0]  f_mask [4];
  logic [15:0]  f_crc [4];
  logic         wake, pd_act, fwd_en;
  logic [1:0]   cause;

  int tests = 0, fails = 0, cycles = 0;

  always #4 clk = ~clk;

  wake_frame_detector uut (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_valid_i(rx_valid), .rx_sof_i(rx_sof), .rx_eof_i(rx_eof), .rx_good_i(rx_good),
    .rx_data_i(rx_data), .pd_set_i(pd_set), .magic_en_i(magic_en), .wkfrm_en_i(wkfrm_en),
    .station_mac_i(mac), .flt_en_i(f_en), .flt_ucast_i(f_uc),
    .flt_offset_i({f_off[3], f_off[2], f_off[1], f_off[0]}),
    .flt_mask_i({f_mask[3], f_mask[2], f_mask[1], f_mask[0]}),
    .flt_crc_i({f_crc[3], f_crc[2], f_crc[1], f_crc[0]}),
    .stat_rd_i(stat_rd),
    .wake_o(wake), .pd_active_o(pd_act), .fwd_en_o(fwd_en), .cause_o(cause)
  );

  function automatic logic [15:0] crc_byte(logic [15:0] c, logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      logic fb;
      fb = c[15] ^ b[i];
      c = c << 1;
      if (fb) c = c ^ 16'h8005;
    end
    return c;
  endfunction

  function automatic logic [15:0] filt_crc(bq_t fr, logic [31:0] m, int off);
    logic [15:0] c = 16'hFFFF;
    for (int j = 0; j < fr.size(); j++)
      if (j >= off && j - off < 32 && m[j - off]) c = crc_byte(c, fr[j]);
    return c;
  endfunction

  function automatic bit has_magic(bq_t fr);
    for (int i = 0; i + 102 <= fr.size(); i++) begin
      bit ok = 1;
      for (int s = 0; s < 6; s++) if (fr[i+s] != 8'hFF) ok = 0;
      for (int t = 0; t < 96; t++) if (fr[i+6+t] != mac[47 - 8*(t%6) -: 8]) ok = 0;
      if (ok) return 1;
    end
    return 0;
  endfunction

  // behavioural reference, advanced on each rising edge
  bq_t          m_q;
  logic         m_pd, m_wake;
  logic [1:0]   m_cause;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pd = 0; m_wake = 0; m_cause = 0; m_q.delete();
    end else begin
      bit hm, hf;
      hm = 0; hf = 0;
      if (rx_valid) begin
        if (rx_sof) m_q.delete();
        m_q.push_back(rx_data);
        if (rx_eof && rx_good && m_pd) begin
          hm = magic_en && has_magic(m_q);
          for (int f = 0; f < 4; f++)
            if (wkfrm_en && f_en[f] && !(f_uc[f] && m_q[0][0]) &&
                filt_crc(m_q, f_mask[f], f_off[f]) == f_crc[f]) hf = 1;
        end
      end
      if (stat_rd) m_cause = 0;
      m_cause = m_cause | {hf, hm};
      m_wake = hm | hf;
      if (m_wake) m_pd = 0;
      else if (pd_set) m_pd = 1;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R9 wake_o", wake, m_wake);
    chk("R2 pd_active_o", pd_act, m_pd);
    chk("R1 fwd_en_o", fwd_en, !m_pd);
    chk("R10 cause_o", cause, m_cause);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic send(bq_t fr, bit good, bit rd_at_end = 0);
    for (int j = 0; j < fr.size(); j++) begin
      @(negedge clk);
      rx_valid = 1; rx_data = fr[j];
      rx_sof = (j == 0); rx_eof = (j == fr.size() - 1);
      rx_good = rx_eof && good;
      stat_rd = rx_eof && rd_at_end;
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_good = 0; stat_rd = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_pd();
    @(negedge clk); pd_set = 1;
    @(negedge clk); pd_set = 0;
  endtask

  task automatic read_stat();
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0;
  endtask

  initial begin
    bq_t fa, fx, mg, mgb, mgx;
    for (int f = 0; f < 4; f++) begin f_off[f] = 0; f_mask[f] = 0; f_crc[f] = 0; end
    for (int j = 0; j < 64; j++) fa.push_back(8'((j * 7 + 3) & 8'hFF));
    fa[0] = 8'h10;
    f_mask[0] = 32'h0000_F00F; f_off[0] = 0;  f_crc[0] = filt_crc(fa, f_mask[0], 0);
    f_mask[1] = 32'h8000_0005; f_off[1] = 20; f_crc[1] = filt_crc(fa, f_mask[1], 20);
    f_en = 4'b0001;

    repeat (3) @(negedge clk);
    chk("R1 reset fwd_en", fwd_en, 1); chk("R1 reset pd", pd_act, 0);
    chk("R1 reset wake", wake, 0);     chk("R1 reset cause", cause, 0);
    rst_n = 1;
    @(negedge clk);

    send(fa, 1);                       // matching frame outside power-down
    chk("R3 no wake outside pd", cause, 0);

    pulse_pd();
    chk("R2 pd entered", pd_act, 1); chk("R1 fwd blocked", fwd_en, 0);

    send(fa, 0);
    chk("R3 bad frame keeps pd", pd_act, 1); chk("R3 bad frame no cause", cause, 0);

    send(fa, 1);
    chk("R4 filter0 wake cause", cause, 2'b10); chk("R9 pd cleared", pd_act, 0);
    chk("R9 pulse over", wake, 0);
    read_stat();
    chk("R10 read clears", cause, 0);

    f_en = 4'b0010;
    fx = fa; fx[21] = 8'hA5;           // masked-out byte
    pulse_pd(); send(fx, 1);
    chk("R4 masked-out byte ignored", cause, 2'b10); read_stat();
    fx = fa; fx[19] = 8'h5A;           // below offset
    pulse_pd(); send(fx, 1);
    chk("R4 byte below offset ignored", cause, 2'b10); read_stat();
    fx = fa; fx[22] = ~fa[22];         // masked-in byte
    pulse_pd(); send(fx, 1);
    chk("R4 masked-in change blocks", pd_act, 1); chk("R4 no cause", cause, 0);

    f_en = 4'b0000;
    send(fa, 1);
    chk("R5 disabled filter", pd_act, 1);

    f_en = 4'b0010; f_uc = 4'b0010;
    fx = fa; fx[0] = 8'h11;
    send(fx, 1);
    chk("R6 multicast rejected", pd_act, 1);
    send(fa, 1);
    chk("R6 unicast accepted", cause, 2'b10); read_stat();
    f_uc = 0;

    wkfrm_en = 0; pulse_pd(); send(fa, 1);
    chk("R8 frame wake gated", pd_act, 1);
    wkfrm_en = 1; f_en = 0;

    for (int j = 0; j < 12; j++) mg.push_back(8'(j + 8'h20));
    for (int s = 0; s < 6; s++) mg.push_back(8'hFF);
    for (int t = 0; t < 96; t++) mg.push_back(mac[47 - 8*(t%6) -: 8]);
    for (int j = 0; j < 4; j++) mg.push_back(8'h33);
    send(mg, 1);
    chk("R8 magic gated", pd_act, 1);
    magic_en = 1;
    mgb = mg; mgb[18 + 6*9 + 2] = 8'h00;
    send(mgb, 1);
    chk("R7 broken magic", pd_act, 1);
    mgx = mg; mgx.insert(12, 8'hFF); mgx.insert(12, 8'hFF);
    send(mgx, 1);
    chk("R7 extra FF magic", cause, 2'b01);
    repeat (5) @(negedge clk);
    chk("R10 cause sticky", cause, 2'b01);
    pulse_pd(); send(mg, 1);
    chk("R7 exact magic", cause, 2'b01);

    f_en = 4'b0010; magic_en = 0;
    pulse_pd(); send(fa, 1, 1);        // read coincides with new cause
    chk("R10 set wins over clear", cause, 2'b10);

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule